// File: doc/BRIEF.md
# Multiplexed VFD Scan and Brightness Controller

This block scans a vacuum fluorescent display one grid at a time. It drives 32 anode (segment) lines and three grid lines. The grid lines are active low, so an external pre-driver can invert them. A host writes display contents through a three-wire serial port: a chip select, a shift clock and a data line. Each frame fills one grid's row in a small display memory, or sets the brightness value.

Brightness comes from one of two sources. A master device runs its own 10-bit pulse-width window inside every grid slot, and drives that window on a dimming output. A slave device uses the same slot timing, but gates its segments with an external dimming pulse, normally the dimming output of a master. The scan runs either two grids (half duty) or three grids (third duty). The duty can be selected while the block is running.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, `seg_o` is all zero, `grid_n_o` is all ones and `dim_out` is low, whatever the other inputs do.
- R2: At most one bit of `grid_n_o` is low at any time. Bit k low means grid k+1 is being scanned.
- R3: When `duplex_sel` is high, grids 1 and 2 alternate slot by slot and grid 3 is never driven. When it is low, grids 1, 2 and 3 follow in turn.
- R4: A frame is sent with `ser_cs` high. One bit is sampled on each rising edge of `ser_clk`, first bit first. The first two bits are an address and the next 32 bits go to `seg_o[31]` down to `seg_o[0]`. Addresses 00, 01 and 10 store the row of grids 1, 2 and 3. Address 11 loads the dim value from the last 10 bits. The frame takes effect on the falling edge of `ser_cs`.
- R5: Rising edges of `ser_clk` while `ser_cs` is low shift nothing and store nothing.
- R6: A frame that holds any number of bits other than 34 is discarded when `ser_cs` falls. Memory and dim value are unchanged.
- R7: Every grid slot lasts 1024 clocks. The last 2 clocks of each slot have all grids off, so two grids are never driven back to back.
- R8: With `master_sel` high, the scanned grid and its segments are active for min(N, 1022) clocks at the start of each slot, where N is the dim value. N = 0 keeps the display dark, and `dim_in` has no effect.
- R9: With `master_sel` high, `dim_out` is high in exactly the clocks of the master window, in every slot. With `master_sel` low, `dim_out` stays low.
- R10: With `master_sel` low, the scanned grid is active for the 1022 non-blanked clocks of each slot. Segments show data only while `dim_in` (after two synchronizer stages) is high.
- R11: While a grid is active, `seg_o` shows the stored row of that grid whenever segments are enabled. At all other times `seg_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs | input | 1 | Serial chip select, high while a frame is sent |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_dat | input | 1 | Serial data |
| duplex_sel | input | 1 | High: two-grid scan; low: three-grid scan |
| master_sel | input | 1 | High: internal dim window; low: follow `dim_in` |
| dim_in | input | 1 | External dimming pulse, used in slave mode |
| seg_o | output | 32 | Segment (anode) drive, active high |
| grid_n_o | output | 3 | Grid drive, active low |
| dim_out | output | 1 | Master dim window for a chained slave |

## Verification
The hardest case to reach from the ports is the pulse-width boundary. A slot is 1024 clocks, but at most 1022 can be active, so dim values 1022 and 1023 must give the same width while 1021 gives one clock less. The bench loads each dim value by serial frame and counts active-grid clocks over exactly one scan period. That count does not depend on where the slot boundaries fall, so no internal phase needs to be seen. Malformed frames are a second such case: frames of 33 and 35 bits, and clocks sent with chip select low, are each followed by a measurement showing the stored rows unchanged.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef enum logic [1:0] {
    ADR_ROW1 = 2'b00,
    ADR_ROW2 = 2'b01,
    ADR_ROW3 = 2'b10,
    ADR_DIM  = 2'b11
  } frame_adr_e;

  // Active length of the master window, clipped so the blanking tail survives.
  function automatic int unsigned win_limit(input int unsigned dim,
                                            input int unsigned slot,
                                            input int unsigned blank);
    int unsigned cap;
    cap = slot - blank;
    return (dim > cap) ? cap : dim;
  endfunction

  // Grid that follows g, given the scan depth chosen by the duty input.
  function automatic int unsigned next_grid(input int unsigned g,
                                            input logic duplex,
                                            input int unsigned n_tri);
    int unsigned depth;
    depth = duplex ? 2 : n_tri;
    return (g + 1 >= depth) ? 0 : g + 1;
  endfunction

endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else if (s == 0) pipe_q[s] <= d;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/vfd_serial_rx.sv
module vfd_serial_rx #(
  parameter int SEG_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [SEG_W-1:0]  wr_data
);
  localparam int FRAME = ADDR_W + SEG_W;
  localparam int CW    = $clog2(FRAME + 2);

  logic             sclk_d, cs_d;
  logic [FRAME-1:0] shreg_q;
  logic [CW-1:0]    bits_q;

  // named internal events
  logic shift_ev, cs_fall, frame_full;
  assign shift_ev   = cs_s & sclk_s & ~sclk_d;
  assign cs_fall    = cs_d & ~cs_s;
  assign frame_full = (bits_q == CW'(FRAME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b0;
      shreg_q <= '0;
      bits_q  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      wr_en  <= cs_fall & frame_full;
      if (cs_fall) {wr_addr, wr_data} <= shreg_q;
      if (!cs_s) bits_q <= '0;
      else if (shift_ev && bits_q != CW'(FRAME + 1)) bits_q <= bits_q + 1'b1;
      if (shift_ev) shreg_q <= {shreg_q[FRAME-2:0], dat_s};
    end
  end

  AST_CS_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(shreg_q)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= CW'(FRAME + 1)); // R6
  AST_WR_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_d); // R4
endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int DIM_W  = 10,
  parameter int GRID_N = 3,
  parameter int BLANK  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      duplex,
  input  logic                      dim_ld,
  input  logic [DIM_W-1:0]          dim_val,
  output logic [$clog2(GRID_N)-1:0] grid_idx,
  output logic                      master_win,
  output logic                      base_win,
  output logic                      slot_end
);
  localparam int unsigned SLOT = 1 << DIM_W;
  localparam int          GW   = $clog2(GRID_N);

  logic [DIM_W-1:0] tick_q;
  logic [DIM_W-1:0] dim_q;
  logic [GW-1:0]    grid_q;

  assign slot_end   = (tick_q == DIM_W'(SLOT - 1));
  assign base_win   = 32'(tick_q) < (SLOT - BLANK);
  assign master_win = 32'(tick_q) < win_limit(32'(dim_q), SLOT, BLANK);
  assign grid_idx   = grid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      dim_q  <= '0;
      grid_q <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
      if (dim_ld) dim_q <= dim_val;
      if (slot_end) grid_q <= GW'(next_grid(32'(grid_q), duplex, GRID_N));
    end
  end

  AST_DUPLEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && duplex) |=> (grid_idx < GW'(2))); // R3
  AST_GRID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(grid_idx) < GRID_N); // R3
  AST_WIN_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    master_win |-> base_win); // R8
  AST_GRID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_end) |-> $stable(grid_idx)); // R7
endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
  import vfd_scan_pkg::*;
#(
  parameter int SEG_W  = 32,
  parameter int GRID_N = 3,
  parameter int DIM_W  = 10,
  parameter int BLANK  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              duplex_sel,
  input  logic              master_sel,
  input  logic              dim_in,
  output logic [SEG_W-1:0]  seg_o,
  output logic [GRID_N-1:0] grid_n_o,
  output logic              dim_out
);
  localparam int ADDR_W = 2;
  localparam int GW     = $clog2(GRID_N);

  logic cs_s, sclk_s, dat_s, dimin_s;
  vfd_sync #(.W(4), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_cs, ser_clk, ser_dat, dim_in}),
    .q({cs_s, sclk_s, dat_s, dimin_s})
  );

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [SEG_W-1:0]  wr_data;
  vfd_serial_rx #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .dat_s(dat_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic          dim_ld;
  logic [GW-1:0] grid_idx;
  logic          master_win, base_win, slot_end;
  assign dim_ld = wr_en && (wr_addr == ADR_DIM);

  vfd_scan_timer #(.DIM_W(DIM_W), .GRID_N(GRID_N), .BLANK(BLANK)) u_timer (
    .clk(clk), .rst_n(rst_n), .duplex(duplex_sel),
    .dim_ld(dim_ld), .dim_val(wr_data[DIM_W-1:0]),
    .grid_idx(grid_idx), .master_win(master_win),
    .base_win(base_win), .slot_end(slot_end)
  );

  // display rows, one per grid
  logic [SEG_W-1:0] row_q [GRID_N];
  generate
    for (genvar g = 0; g < GRID_N; g++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q[g] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(g)) row_q[g] <= wr_data;
      end
    end
  endgenerate

  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else run_q <= 1'b1;
  end

  logic scan_on, seg_on;
  assign scan_on  = run_q & (master_sel ? master_win : base_win);
  assign seg_on   = run_q & (master_sel ? master_win : (base_win & dimin_s));
  assign grid_n_o = scan_on ? ~(GRID_N'(1) << grid_idx) : '1;
  assign seg_o    = seg_on ? row_q[grid_idx] : '0;
  assign dim_out  = run_q & master_sel & master_win;

  AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~grid_n_o) <= 1); // R2
  AST_BLANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !base_win |-> (grid_n_o == '1)); // R7
  AST_SEG_NEEDS_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_n_o == '1) |-> (seg_o == '0)); // R11
  AST_SLAVE_NO_DIMOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> !dim_out); // R9
  AST_DIMOUT_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    dim_out |-> (grid_n_o != '1)); // R9
endmodule

// File: tb/vfd_scan_ctrl_tb_top.sv
module vfd_scan_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_cs = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic duplex_sel = 1'b0, master_sel = 1'b0, dim_in = 1'b0;
  logic [31:0] seg_o;
  logic [2:0]  grid_n_o;
  logic        dim_out;

  always #10 clk = ~clk; // 50 MHz

  vfd_scan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .duplex_sel(duplex_sel), .master_sel(master_sel),
    .dim_in(dim_in), .seg_o(seg_o), .grid_n_o(grid_n_o), .dim_out(dim_out)
  );

  int tests = 0, fails = 0;
  logic [31:0] exp_row [3];
  int g_cnt [3];
  int seg_cnt, dim_cnt, bad_seg, multi_cnt;
  int gap_err = 0;
  int cyc = 0;
  int prev_g = -1;

  // dim value, expected width per slot
  localparam logic [9:0] VEC_DIM [6] = '{10'd0, 10'd1, 10'd511, 10'd1021, 10'd1022, 10'd1023};
  localparam int         VEC_EXP [6] = '{0, 1, 511, 1021, 1022, 1022};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int decode(input logic [2:0] gn);
    case (gn)
      3'b110: return 0;
      3'b101: return 1;
      3'b011: return 2;
      3'b111: return -1;
      default: return -2;
    endcase
  endfunction

  // R7: no grid may follow another grid without an idle clock between them
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = decode(grid_n_o);
      if (k >= 0 && prev_g >= 0 && k != prev_g) gap_err++;
      prev_g = k;
    end else prev_g = -1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] a, input logic [31:0] d, input int nbits);
    logic [33:0] w;
    w = {a, d};
    @(negedge clk); ser_cs = 1'b1;
    wait_clk(3);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 34) ? w[33-i] : 1'b0;
      wait_clk(3); ser_clk = 1'b1;
      wait_clk(3); ser_clk = 1'b0;
    end
    wait_clk(3); ser_cs = 1'b0;
    wait_clk(10);
  endtask

  task automatic measure(input int cycles);
    g_cnt = '{0, 0, 0};
    seg_cnt = 0; dim_cnt = 0; bad_seg = 0; multi_cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      int k;
      @(negedge clk);
      k = decode(grid_n_o);
      if (k == -2) multi_cnt++;
      if (k >= 0) g_cnt[k]++;
      if (seg_o != 0) seg_cnt++;
      if (dim_out) dim_cnt++;
      if (seg_o != 0 && (k < 0 || seg_o != exp_row[k])) bad_seg++;
    end
  endtask

  initial begin
    exp_row = '{32'h0, 32'h0, 32'h0};
    // R1: reset blanks everything, even in slave mode with dim_in high
    master_sel = 1'b0; dim_in = 1'b1;
    wait_clk(5);
    chk("R1 seg", int'(seg_o), 0);
    chk("R1 grid", int'(grid_n_o), 7);
    chk("R1 dimout", int'(dim_out), 0);
    master_sel = 1'b1; dim_in = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(3);

    // R4: load three rows and a dim value
    send_frame(2'b00, 32'hA5A5_5A5A, 34); exp_row[0] = 32'hA5A5_5A5A;
    send_frame(2'b01, 32'h1234_5678, 34); exp_row[1] = 32'h1234_5678;
    send_frame(2'b10, 32'h8000_0001, 34); exp_row[2] = 32'h8000_0001;
    send_frame(2'b11, 32'd300, 34);
    measure(3072);
    chk("R3 tri g1", g_cnt[0], 300);
    chk("R3 tri g2", g_cnt[1], 300);
    chk("R3 tri g3", g_cnt[2], 300);
    chk("R11 seg rows", bad_seg, 0);
    chk("R11 seg on", seg_cnt, 900);
    chk("R9 dim_out", dim_cnt, 900);
    chk("R2 one grid", multi_cnt, 0);

    // R8: dim width table, one scan period per entry
    for (int v = 0; v < 6; v++) begin
      send_frame(2'b11, {22'd0, VEC_DIM[v]}, 34);
      measure(3072);
      chk("R8 width", g_cnt[0], VEC_EXP[v]);
      chk("R9 dim_out width", dim_cnt, 3 * VEC_EXP[v]);
    end

    // R3: duplex scan uses two grids only
    duplex_sel = 1'b1;
    wait_clk(3100);
    measure(2048);
    chk("R3 dup g1", g_cnt[0], 1022);
    chk("R3 dup g2", g_cnt[1], 1022);
    chk("R3 dup g3", g_cnt[2], 0);
    duplex_sel = 1'b0;
    wait_clk(2100);

    // R8: dim_in ignored in master mode
    send_frame(2'b11, 32'd200, 34);
    dim_in = 1'b0;
    measure(3072);
    chk("R8 dim_in low", seg_cnt, 600);
    dim_in = 1'b1;
    measure(3072);
    chk("R8 dim_in high", seg_cnt, 600);

    // R10: slave mode follows dim_in
    master_sel = 1'b0;
    wait_clk(5);
    measure(3072);
    chk("R10 slave grid", g_cnt[0], 1022);
    chk("R10 slave seg", seg_cnt, 3066);
    chk("R10 slave rows", bad_seg, 0);
    chk("R9 slave dim_out", dim_cnt, 0);
    dim_in = 1'b0;
    wait_clk(5);
    measure(3072);
    chk("R10 slave grid off", g_cnt[0], 1022);
    chk("R10 slave seg off", seg_cnt, 0);
    master_sel = 1'b1;

    // R5: clocks with chip select low, then an empty select pulse
    for (int i = 0; i < 34; i++) begin
      ser_dat = ~ser_dat;
      wait_clk(3); ser_clk = 1'b1;
      wait_clk(3); ser_clk = 1'b0;
    end
    send_frame(2'b00, 32'h0, 0);
    measure(3072);
    chk("R5 cs low ignored", bad_seg, 0);
    chk("R5 width kept", g_cnt[0], 200);

    // R6: short and long frames dropped
    send_frame(2'b00, 32'hFFFF_FFFF, 33);
    send_frame(2'b11, 32'd5, 35);
    measure(3072);
    chk("R6 rows kept", bad_seg, 0);
    chk("R6 dim kept", g_cnt[0], 200);

    // R4: a valid frame after the bad ones is taken
    send_frame(2'b00, 32'h0F0F_0F0F, 34); exp_row[0] = 32'h0F0F_0F0F;
    measure(3072);
    chk("R4 new row", bad_seg, 0);
    chk("R4 new row width", g_cnt[0], 200);

    chk("R7 blank gap", gap_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule